// File: doc/BRIEF.md
# RNMI Status Register

This block holds the machine-level status register that a hart consults when it takes a resumable non-maskable interrupt (RNMI). When the interrupt is taken, the register records where the hart was: its privilege level, whether it was running as a virtualized guest, and whether a landing pad was expected. It also drops the global RNMI enable so that a second RNMI cannot overwrite that record. The return instruction raises the enable again. The saved fields drive the return path, and software can read them and rewrite them through the CSR port.

Software reaches the register at CSR address 0x744, and only from Machine privilege. A read, write, set or clear from any lower privilege raises the illegal flag. Such an access returns zero and changes nothing. Set and clear are folded into a read-modify-write image before each field applies its own write rule. The enable is a one-way bit for software: software may raise it but can never lower it.

The enable is tracked by a three-state machine.
- `EN_RESET_OFF` is the state after reset, with the enable low.
- `EN_ARMED` is the only state with the enable high.
- `EN_IN_HANDLER` is entered on RNMI entry, with the enable low.

The transitions, in priority order, are:
- Entry moves any state to `EN_IN_HANDLER`.
- Return moves `EN_RESET_OFF` or `EN_IN_HANDLER` to `EN_ARMED`.
- A software set moves `EN_RESET_OFF` or `EN_IN_HANDLER` to `EN_ARMED`.

Every other case holds the current state.

Top module: `rnmi_status_csr`

## Requirements
- R1: After reset the register reads 0x0: the enable is low and every saved field is zero.
- R2: An access at address 0x744 from a privilege other than Machine (3), or any access there when the register is not implemented, asserts `csr_illegal`, returns zero read data and changes no state. An access at any other address returns zero and does not assert the flag.
- R3: Read layout: bit 3 is the enable, bit 7 the saved virtualization mode (1 = guest), bit 9 the saved expected-landing-pad state, and bits 12:11 the saved privilege (0 User, 1 Supervisor, 3 Machine). Every other bit reads zero, and writes to those bits are ignored.
- R4: A software update whose merged bit 3 is 1 raises the enable. A merged bit 3 of 0, whether from a write of 0 or from a clear, leaves the enable unchanged.
- R5: `csr_op` selects the update: 0 read (no change), 1 write (new = data), 2 set (new = old | data), 3 clear (new = old & ~data). The result feeds the per-field write rules.
- R6: The saved privilege never holds 2. A software write or an entry capture of 2, or of 1 when Supervisor is absent, keeps the previous value.
- R7: The virtualization and landing-pad fields are writable only when their options are configured. Otherwise they read zero.
- R8: On `nmi_enter` the enable falls, and the privilege, virtualization and landing-pad inputs are captured into their fields.
- R9: On `nmi_return` the enable rises and the saved fields are left unchanged.
- R10: A hardware event blocks a same-cycle software write, which is then dropped entirely. When entry and return occur together, entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | CSR access present this cycle |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | XLEN | Write or mask data |
| cur_priv | input | 2 | Privilege of the accessing instruction |
| nmi_enter | input | 1 | RNMI taken this cycle |
| enter_priv | input | 2 | Privilege of the interrupted context |
| enter_virt | input | 1 | Virtualization mode of the interrupted context |
| enter_elp | input | 1 | Expected-landing-pad state of the interrupted context |
| nmi_return | input | 1 | RNMI return executed this cycle |
| csr_rdata | output | XLEN | Register image (pre-update) for a legal access, else zero |
| csr_illegal | output | 1 | Illegal access indication |
| nmi_enable | output | 1 | Global RNMI enable |
| saved_priv | output | 2 | Saved previous privilege |
| saved_virt | output | 1 | Saved virtualization mode |
| saved_elp | output | 1 | Saved expected-landing-pad state |

## Verification
The bench goes after several corner cases, each of which exposes a specific design mistake.
- Clears aimed at the enable: a write of zero or a clear mask covering bit 3. A design that let software lower the bit would then read 0x0 where 0x8 is expected.
- Reserved privilege encoding 2, reached by a direct write, by a clear that carves 3 into 2, and by an entry capture. A design that failed to legalise would read bits 12:11 as 2.
- Hardware entry or return in the same cycle as a software write, and entry in the same cycle as return. Wrong precedence shows up as software-written fields, or as a high enable after the combined event.
- Low-privilege and off-address accesses. A design that checked these loosely would leak read data or apply the write.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;

    localparam logic [11:0] RNMI_CSR_ADDR = 12'h744;

    // Bit positions that the return path and software decode
    localparam int unsigned POS_EN     = 3;
    localparam int unsigned POS_VIRT   = 7;
    localparam int unsigned POS_ELP    = 9;
    localparam int unsigned POS_PRV_LO = 11;
    localparam int unsigned POS_PRV_HI = 12;
    localparam int unsigned IMG_BITS   = POS_PRV_HI + 1;

    localparam logic [1:0] PRV_USER  = 2'd0;
    localparam logic [1:0] PRV_SUPER = 2'd1;
    localparam logic [1:0] PRV_RSVD  = 2'd2;
    localparam logic [1:0] PRV_MACH  = 2'd3;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        EN_RESET_OFF  = 2'd0,
        EN_ARMED      = 2'd1,
        EN_IN_HANDLER = 2'd2
    } en_state_e;

    // Software-visible bits of the register, in compact form
    typedef struct packed {
        logic [1:0] prv;
        logic       elp;
        logic       virt;
        logic       en;
    } field_img_t;

    // Saved interrupted-context fields
    typedef struct packed {
        logic [1:0] prv;
        logic       elp;
        logic       virt;
    } saved_ctx_t;

    function automatic logic prv_legal(input logic [1:0] p, input logic has_s);
        unique case (p)
            PRV_USER:  prv_legal = 1'b1;
            PRV_SUPER: prv_legal = has_s;
            PRV_MACH:  prv_legal = 1'b1;
            default:   prv_legal = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rnmi_access_check.sv
module rnmi_access_check
    import rnmi_pkg::*;
#(
    parameter bit IMPLEMENTED = 1'b1
) (
    input  logic        csr_valid,
    input  logic [11:0] csr_addr,
    input  logic [1:0]  cur_priv,
    output logic        access_ok,
    output logic        access_bad
);

    logic addr_hit;
    logic priv_ok;

    always_comb begin
        addr_hit   = csr_valid && (csr_addr == RNMI_CSR_ADDR);
        priv_ok    = (cur_priv == PRV_MACH);
        access_bad = addr_hit && (!IMPLEMENTED || !priv_ok);
        access_ok  = addr_hit && IMPLEMENTED && priv_ok;
    end

endmodule

// File: rtl/rnmi_write_merge.sv
module rnmi_write_merge
    import rnmi_pkg::*;
#(
    parameter bit HAS_SUPERVISOR  = 1'b1,
    parameter bit HAS_HYPERVISOR  = 1'b1,
    parameter bit HAS_LANDING_PAD = 1'b1
) (
    input  logic       do_write,
    input  logic [1:0] op,
    input  field_img_t cur_img,
    input  field_img_t wr_img,
    output saved_ctx_t ctx_nxt,
    output logic       set_en
);

    field_img_t merged;

    // Read-modify-write image of the five live bits
    always_comb begin
        unique case (csr_op_e'(op))
            OP_WRITE: merged = wr_img;
            OP_SET:   merged = cur_img | wr_img;
            OP_CLEAR: merged = cur_img & ~wr_img;
            default:  merged = cur_img;
        endcase
    end

    // Per-field write rules
    always_comb begin
        ctx_nxt.prv  = prv_legal(merged.prv, HAS_SUPERVISOR) ? merged.prv : cur_img.prv;
        ctx_nxt.virt = HAS_HYPERVISOR  ? merged.virt : 1'b0;
        ctx_nxt.elp  = HAS_LANDING_PAD ? merged.elp  : 1'b0;
        set_en       = do_write && merged.en;
    end

endmodule

// File: rtl/rnmi_enable_fsm.sv
module rnmi_enable_fsm
    import rnmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_enter,
    input  logic hw_return,
    input  logic sw_set,
    output logic enable
);

    en_state_e state_q;
    en_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EN_RESET_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_RESET_OFF: begin
                if (hw_enter)       state_d = EN_IN_HANDLER;
                else if (hw_return) state_d = EN_ARMED;
                else if (sw_set)    state_d = EN_ARMED;
            end
            EN_ARMED: begin
                if (hw_enter)       state_d = EN_IN_HANDLER;
            end
            EN_IN_HANDLER: begin
                if (hw_enter)       state_d = EN_IN_HANDLER;
                else if (hw_return) state_d = EN_ARMED;
                else if (sw_set)    state_d = EN_ARMED;
            end
            default:                state_d = EN_RESET_OFF;
        endcase
    end

    always_comb begin
        enable = (state_q == EN_ARMED);
    end

endmodule

// File: rtl/rnmi_status_csr.sv
module rnmi_status_csr
    import rnmi_pkg::*;
#(
    parameter int unsigned XLEN            = 64,
    parameter bit          IMPLEMENTED     = 1'b1,
    parameter bit          HAS_SUPERVISOR  = 1'b1,
    parameter bit          HAS_HYPERVISOR  = 1'b1,
    parameter bit          HAS_LANDING_PAD = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_valid,
    input  logic [11:0]     csr_addr,
    input  logic [1:0]      csr_op,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [1:0]      cur_priv,
    input  logic            nmi_enter,
    input  logic [1:0]      enter_priv,
    input  logic            enter_virt,
    input  logic            enter_elp,
    input  logic            nmi_return,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    output logic            nmi_enable,
    output logic [1:0]      saved_priv,
    output logic            saved_virt,
    output logic            saved_elp
);

    localparam int unsigned HI_BITS = XLEN - IMG_BITS;

    logic       access_ok;
    logic       hw_event;
    logic       sw_write;
    logic       set_en;
    field_img_t cur_img;
    field_img_t wr_img;
    saved_ctx_t ctx_nxt;
    logic [XLEN-1:0] img;
    logic       unused_wdata_bits;

    rnmi_access_check #(
        .IMPLEMENTED (IMPLEMENTED)
    ) acc_i (
        .csr_valid  (csr_valid),
        .csr_addr   (csr_addr),
        .cur_priv   (cur_priv),
        .access_ok  (access_ok),
        .access_bad (csr_illegal)
    );

    always_comb begin
        hw_event = nmi_enter || nmi_return;
        sw_write = access_ok && (csr_op != OP_READ) && !hw_event;
        cur_img  = '{prv: saved_priv, elp: saved_elp, virt: saved_virt, en: nmi_enable};
        wr_img   = '{prv:  csr_wdata[POS_PRV_HI:POS_PRV_LO],
                     elp:  csr_wdata[POS_ELP],
                     virt: csr_wdata[POS_VIRT],
                     en:   csr_wdata[POS_EN]};
    end

    assign unused_wdata_bits = ^{csr_wdata[XLEN-1:IMG_BITS], csr_wdata[10],
                                 csr_wdata[8], csr_wdata[6:4], csr_wdata[2:0]};

    rnmi_write_merge #(
        .HAS_SUPERVISOR  (HAS_SUPERVISOR),
        .HAS_HYPERVISOR  (HAS_HYPERVISOR),
        .HAS_LANDING_PAD (HAS_LANDING_PAD)
    ) mrg_i (
        .do_write (sw_write),
        .op       (csr_op),
        .cur_img  (cur_img),
        .wr_img   (wr_img),
        .ctx_nxt  (ctx_nxt),
        .set_en   (set_en)
    );

    rnmi_enable_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_enter  (nmi_enter),
        .hw_return (nmi_return),
        .sw_set    (set_en),
        .enable    (nmi_enable)
    );

    // Saved privilege: entry capture first, then software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_priv <= PRV_USER;
        end else if (nmi_enter) begin
            if (prv_legal(enter_priv, HAS_SUPERVISOR)) saved_priv <= enter_priv;
        end else if (sw_write) begin
            saved_priv <= ctx_nxt.prv;
        end
    end

    generate
        if (HAS_HYPERVISOR) begin : g_virt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         saved_virt <= 1'b0;
                else if (nmi_enter) saved_virt <= enter_virt;
                else if (sw_write)  saved_virt <= ctx_nxt.virt;
            end
        end else begin : g_no_virt
            logic unused_virt;
            assign unused_virt = enter_virt ^ ctx_nxt.virt;
            assign saved_virt  = 1'b0;
        end

        if (HAS_LANDING_PAD) begin : g_elp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         saved_elp <= 1'b0;
                else if (nmi_enter) saved_elp <= enter_elp;
                else if (sw_write)  saved_elp <= ctx_nxt.elp;
            end
        end else begin : g_no_elp
            logic unused_elp;
            assign unused_elp = enter_elp ^ ctx_nxt.elp;
            assign saved_elp  = 1'b0;
        end
    endgenerate

    // Read image: pre-update value, zero outside legal accesses
    always_comb begin
        img                         = '0;
        img[POS_PRV_HI:POS_PRV_LO]  = saved_priv;
        img[POS_ELP]                = saved_elp;
        img[POS_VIRT]               = saved_virt;
        img[POS_EN]                 = nmi_enable;
        csr_rdata                   = access_ok ? img : {XLEN{1'b0}};
    end

    if (HI_BITS == 0) begin : g_xlen_chk
        initial $display("rnmi_status_csr: XLEN leaves no reserved upper bits");
    end

endmodule

// File: rtl/rnmi_status_csr_chk.sv
module rnmi_status_csr_chk
    import rnmi_pkg::*;
#(
    parameter int unsigned XLEN           = 64,
    parameter bit          HAS_SUPERVISOR = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_valid,
    input logic [11:0]     csr_addr,
    input logic [1:0]      cur_priv,
    input logic            nmi_enter,
    input logic [1:0]      enter_priv,
    input logic            nmi_return,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_illegal,
    input logic            nmi_enable,
    input logic [1:0]      saved_priv
);

    localparam logic [XLEN-1:0] LIVE_MASK =
        (XLEN'(3) << POS_PRV_LO) | (XLEN'(1) << POS_ELP) |
        (XLEN'(1) << POS_VIRT)   | (XLEN'(1) << POS_EN);

    // R8
    entry_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_enter |=> !nmi_enable);

    // R9
    return_sets_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_return && !nmi_enter) |=> nmi_enable);

    // R4
    en_fall_only_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_enable) |-> $past(nmi_enter));

    // R6
    prv_never_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        saved_priv != PRV_RSVD);

    // R2
    low_priv_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_addr == RNMI_CSR_ADDR && cur_priv != PRV_MACH)
            |-> (csr_illegal && csr_rdata == '0));

    // R3
    rsvd_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata & ~LIVE_MASK) == '0);

    // R8
    entry_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_enter && prv_legal(enter_priv, HAS_SUPERVISOR))
            |=> saved_priv == $past(enter_priv));

endmodule

bind rnmi_status_csr rnmi_status_csr_chk #(
    .XLEN           (XLEN),
    .HAS_SUPERVISOR (HAS_SUPERVISOR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_addr    (csr_addr),
    .cur_priv    (cur_priv),
    .nmi_enter   (nmi_enter),
    .enter_priv  (enter_priv),
    .nmi_return  (nmi_return),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .nmi_enable  (nmi_enable),
    .saved_priv  (saved_priv)
);

// File: tb/rnmi_status_csr_tb.sv
`timescale 1ns/1ps
module rnmi_status_csr_tb_top;

    localparam int XLEN = 64;

    typedef struct {
        string           tag;
        logic [XLEN-1:0] rdata;
        logic            illegal;
        logic            en;
    } exp_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_valid = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [1:0]      csr_op = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [1:0]      cur_priv = 2'd3;
    logic            nmi_enter = 1'b0;
    logic [1:0]      enter_priv = '0;
    logic            enter_virt = 1'b0;
    logic            enter_elp = 1'b0;
    logic            nmi_return = 1'b0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_illegal;
    logic            nmi_enable;
    logic [1:0]      saved_priv;
    logic            saved_virt;
    logic            saved_elp;

    exp_item_t exp_q[$];
    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    rnmi_status_csr #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .cur_priv(cur_priv),
        .nmi_enter(nmi_enter), .enter_priv(enter_priv), .enter_virt(enter_virt),
        .enter_elp(enter_elp), .nmi_return(nmi_return), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .nmi_enable(nmi_enable), .saved_priv(saved_priv),
        .saved_virt(saved_virt), .saved_elp(saved_elp)
    );

    // Expected image from the R3 layout
    function automatic logic [XLEN-1:0] img(input logic [1:0] p, input logic v,
                                            input logic l, input logic e);
        img = (XLEN'(p) << 11) | (XLEN'(l) << 9) | (XLEN'(v) << 7) | (XLEN'(e) << 3);
    endfunction

    task automatic drive(input logic v, input logic [1:0] op, input logic [11:0] a,
                         input logic [1:0] pr, input logic [XLEN-1:0] d,
                         input logic ent, input logic [1:0] ep, input logic ev,
                         input logic el, input logic ret);
        @(posedge clk);
        #1;
        csr_valid = v; csr_op = op; csr_addr = a; cur_priv = pr; csr_wdata = d;
        nmi_enter = ent; enter_priv = ep; enter_virt = ev; enter_elp = el;
        nmi_return = ret;
    endtask

    task automatic sw(input logic [1:0] op, input logic [XLEN-1:0] d);
        drive(1'b1, op, 12'h744, 2'd3, d, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic expect_now(input string tag, input logic [XLEN-1:0] rd,
                              input logic ill, input logic en);
        exp_item_t it;
        it.tag = tag; it.rdata = rd; it.illegal = ill; it.en = en;
        exp_q.push_back(it);
    endtask

    task automatic check_read(input string tag, input logic [XLEN-1:0] rd, input logic en);
        sw(2'd0, '0);
        expect_now(tag, rd, 1'b0, en);
    endtask

    // Monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            n_tests++;
            if (csr_rdata !== it.rdata || csr_illegal !== it.illegal || nmi_enable !== it.en) begin
                n_fail++;
                $display("FAIL %s: rdata=%h illegal=%b en=%b expected rdata=%h illegal=%b en=%b",
                         it.tag, csr_rdata, csr_illegal, nmi_enable,
                         it.rdata, it.illegal, it.en);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        check_read("R1 reset image", '0, 1'b0);

        drive(1'b1, 2'd1, 12'h744, 2'd1, '1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        expect_now("R2 supervisor write flagged", '0, 1'b1, 1'b0);
        check_read("R2 blocked write left state", '0, 1'b0);

        sw(2'd1, '1);
        check_read("R3 R7 all-ones write masks reserved bits", img(2'd3, 1, 1, 1), 1'b1);

        sw(2'd1, '0);
        check_read("R4 write of zero keeps enable", img(2'd0, 0, 0, 1), 1'b1);

        sw(2'd3, 64'h8);
        check_read("R4 clear of enable ignored", img(2'd0, 0, 0, 1), 1'b1);

        sw(2'd2, 64'h800);
        check_read("R5 set op to supervisor", img(2'd1, 0, 0, 1), 1'b1);

        sw(2'd1, 64'h1000);
        check_read("R6 write of encoding 2 keeps field", img(2'd1, 0, 0, 1), 1'b1);

        sw(2'd2, 64'h1000);
        check_read("R5 set op merges to machine", img(2'd3, 0, 0, 1), 1'b1);

        sw(2'd3, 64'h800);
        check_read("R6 clear carving encoding 2 kept", img(2'd3, 0, 0, 1), 1'b1);

        drive(1'b0, 2'd0, 12'h0, 2'd3, '0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0);
        check_read("R8 entry capture and mask", img(2'd1, 1, 1, 0), 1'b0);

        drive(1'b0, 2'd0, 12'h0, 2'd3, '0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        check_read("R9 return sets enable only", img(2'd1, 1, 1, 1), 1'b1);

        drive(1'b1, 2'd1, 12'h744, 2'd3, '1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        check_read("R10 entry beats software write", img(2'd0, 0, 0, 0), 1'b0);

        drive(1'b1, 2'd1, 12'h744, 2'd3, 64'h1A80, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        check_read("R10 return drops software write", img(2'd0, 0, 0, 1), 1'b1);

        drive(1'b0, 2'd0, 12'h0, 2'd3, '0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1);
        check_read("R10 entry beats return", img(2'd3, 0, 0, 0), 1'b0);

        drive(1'b0, 2'd0, 12'h0, 2'd3, '0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
        check_read("R6 entry with encoding 2 kept", img(2'd3, 0, 0, 0), 1'b0);

        sw(2'd1, 64'h8);
        check_read("R4 software set from handler", img(2'd0, 0, 0, 1), 1'b1);

        drive(1'b1, 2'd0, 12'h300, 2'd3, '0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        expect_now("R2 other address reads zero", '0, 1'b0, 1'b1);

        drive(1'b1, 2'd0, 12'h744, 2'd0, '0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        expect_now("R2 user read flagged", '0, 1'b1, 1'b1);

        drive(1'b0, 2'd0, 12'h0, 2'd3, '0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule